// File: doc/BRIEF.md
# Single-Wire Pulse-Count Voltage Programmer

This block turns one control wire into an enable flag and a 5-bit output-voltage code for a negative supply rail. The wire is sampled on the system clock through a synchronizer. A high level on a disabled block turns the rail on at the default code. After an initialization window, valid low pulses are counted by their rising edges. The count becomes the new code once the wire has stayed high for a storage interval.

A low level that lasts the shut-down interval disables the rail and discards any count not yet committed. Low pulses that are too short or too long are ignored. All time limits are parameters expressed in clock ticks. Code k selects (-4.4 + 0.1·(k-1)) V for k from 1 to 31. The default code 5 therefore means -4.0 V. The analog converter and the ramping of the rail are outside this block.

Top module: `swire_vcode_prog`

## Requirements
- R1: After reset the rail enable is 0, the code is 5 and the code strobe is 0.
- R2: While disabled, a high synchronized line sets the enable to 1, loads code 5 and raises the strobe for one clock.
- R3: Rising edges that occur within INIT_TICKS clocks of enable are not counted and cause no commit.
- R4: Each rising edge that ends a low run of MIN_LOW_TICKS to MAX_LOW_TICKS clocks adds one to the pending count. On commit the code equals the count, so 3 edges give code 3 (-4.2 V) and 1 edge gives code 1 (-4.4 V).
- R5: A rising edge after a low run shorter than MIN_LOW_TICKS, or longer than MAX_LOW_TICKS but shorter than OFF_TICKS, does not change the count or the enable.
- R6: A pending count is committed when the line has been high for STORE_TICKS clocks. The code changes only in a cycle where the strobe is high, and the strobe lasts exactly one clock.
- R7: The pending count saturates at 31.
- R8: A low run of OFF_TICKS clocks clears the enable and discards the pending count, while the code holds its value. The next high level re-enables the block at code 5.
- R9: After a commit the next sequence counts from zero, and the previous code is held until that sequence commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_line_i | input | 1 | Combined enable and programming wire (asynchronous) |
| rail_en_o | output | 1 | Rail enable flag |
| vcode_o | output | 5 | Committed voltage code |
| vcode_stb_o | output | 1 | One-clock strobe when vcode_o is loaded |

## Verification
The assertions assume that OFF_TICKS exceeds MAX_LOW_TICKS. They also assume that any high gap inside a programming sequence is shorter than STORE_TICKS, so run lengths measured on the synchronized line classify every pulse the same way each time. The bench meets these assumptions by driving the wire only on falling clock edges, in whole-clock widths, with a configuration of short tick limits. Width stimulus sits exactly on the limits and one tick past them. Shut-down lows exceed OFF_TICKS by a margin that covers the synchronizer delay.

// File: rtl/swp_pkg.sv
`timescale 1ns/1ps
package swp_pkg;
  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_DEFAULT = 5'd5;
  localparam logic [CODE_W-1:0] CODE_MAX = 5'd31;

  typedef enum logic [1:0] {ST_OFF, ST_INIT, ST_IDLE, ST_PROG} seq_st_t;

  // saturating increment of the pending edge count
  function automatic logic [CODE_W-1:0] sat_inc(input logic [CODE_W-1:0] v);
    return (v == CODE_MAX) ? v : v + 1'b1;
  endfunction

  // inclusive width window test
  function automatic logic in_window(input int unsigned w, input int unsigned lo,
                                     input int unsigned hi);
    return (w >= lo) && (w <= hi);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/swp_linemon.sv
`timescale 1ns/1ps
module swp_linemon #(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic [RUN_W-1:0] lo_run_o,
  output logic [RUN_W-1:0] hi_run_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic [RUN_W-1:0]       lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      lvl_q  <= sync_q[SYNC_STAGES-1];
    end
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~lvl_q;

  // run-length counters: each counts clocks of its own level, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (!lvl_o) lo_q <= (&lo_q) ? lo_q : lo_q + 1'b1;
    else             lo_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (lvl_o) hi_q <= (&hi_q) ? hi_q : hi_q + 1'b1;
    else            hi_q <= '0;
  end

  assign lo_run_o = lo_q;
  assign hi_run_o = hi_q;
endmodule

// File: rtl/swp_seq.sv
`timescale 1ns/1ps
module swp_seq
  import swp_pkg::*;
#(
  parameter int MIN_LOW_TICKS = 20,
  parameter int MAX_LOW_TICKS = 250,
  parameter int INIT_TICKS = 4000,
  parameter int STORE_TICKS = 600,
  parameter int OFF_TICKS = 600,
  parameter int RUN_W = 10,
  parameter int INIT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_i,
  input  logic              rise_i,
  input  logic [RUN_W-1:0]  lo_run_i,
  input  logic [RUN_W-1:0]  hi_run_i,
  output logic              en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              stb_o
);
  seq_st_t           st_q;
  logic [INIT_W-1:0] init_q;
  logic [CODE_W-1:0] cnt_q, code_q;
  logic              en_q, stb_q;

  // named internal events
  logic edge_ok, count_now, store_now, off_now, init_done, glitch;
  assign edge_ok   = rise_i && in_window(32'(lo_run_i), MIN_LOW_TICKS, MAX_LOW_TICKS);
  assign glitch    = rise_i && (32'(lo_run_i) < MIN_LOW_TICKS);
  assign count_now = edge_ok && ((st_q == ST_IDLE) || (st_q == ST_PROG));
  assign store_now = (st_q == ST_PROG) && lvl_i && (32'(hi_run_i) == STORE_TICKS);
  assign off_now   = (st_q != ST_OFF) && !lvl_i && (32'(lo_run_i) >= OFF_TICKS);
  assign init_done = (st_q == ST_INIT) && (32'(init_q) >= INIT_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      init_q <= '0;
      cnt_q  <= '0;
      code_q <= CODE_DEFAULT;
      en_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (st_q == ST_OFF) begin
        if (lvl_i) begin
          st_q   <= ST_INIT;
          en_q   <= 1'b1;
          code_q <= CODE_DEFAULT;
          stb_q  <= 1'b1;
          init_q <= '0;
          cnt_q  <= '0;
        end
      end else if (off_now) begin
        st_q  <= ST_OFF;
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (st_q == ST_INIT) begin
          init_q <= init_q + 1'b1;
          if (init_done) st_q <= ST_IDLE;
        end
        if (count_now) begin
          cnt_q <= sat_inc(cnt_q);
          st_q  <= ST_PROG;
        end else if (store_now) begin
          code_q <= cnt_q;
          stb_q  <= 1'b1;
          cnt_q  <= '0;
          st_q   <= ST_IDLE;
        end
      end
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;
  assign stb_o  = stb_q;

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> (stb_q && code_q == CODE_DEFAULT));
  // R3
  init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_INIT) |-> (cnt_q == '0));
  // R5
  glitch_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> $stable(cnt_q));
  // R6
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> stb_q);
  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_now && cnt_q == CODE_MAX) |=> (cnt_q == CODE_MAX));
  // R8
  shut_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(32'(lo_run_i)) >= OFF_TICKS && cnt_q == '0));
endmodule

// File: rtl/swire_vcode_prog.sv
`timescale 1ns/1ps
module swire_vcode_prog
  import swp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW_TICKS = 20,
  parameter int MAX_LOW_TICKS = 250,
  parameter int INIT_TICKS = 4000,
  parameter int STORE_TICKS = 600,
  parameter int OFF_TICKS = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_line_i,
  output logic       rail_en_o,
  output logic [4:0] vcode_o,
  output logic       vcode_stb_o
);
  localparam int RUN_W  = $clog2(max3(OFF_TICKS, STORE_TICKS, MAX_LOW_TICKS) + 2);
  localparam int INIT_W = $clog2(INIT_TICKS + 2);

  logic             lvl, rise;
  logic [RUN_W-1:0] lo_run, hi_run;

  swp_linemon #(.SYNC_STAGES(SYNC_STAGES), .RUN_W(RUN_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .line_i(ctrl_line_i),
    .lvl_o(lvl), .rise_o(rise), .lo_run_o(lo_run), .hi_run_o(hi_run)
  );

  swp_seq #(
    .MIN_LOW_TICKS(MIN_LOW_TICKS), .MAX_LOW_TICKS(MAX_LOW_TICKS),
    .INIT_TICKS(INIT_TICKS), .STORE_TICKS(STORE_TICKS), .OFF_TICKS(OFF_TICKS),
    .RUN_W(RUN_W), .INIT_W(INIT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_i(rise),
    .lo_run_i(lo_run), .hi_run_i(hi_run),
    .en_o(rail_en_o), .code_o(vcode_o), .stb_o(vcode_stb_o)
  );
endmodule

// File: tb/test_swire_vcode_prog.sv
`timescale 1ns/1ps
module test_swire_vcode_prog;
  localparam int MINL = 4, MAXL = 20, INIT = 40, STORE = 30, OFF = 60;

  logic clk = 1'b0, rst_n = 1'b0, ctrl = 1'b0;
  logic en, stb;
  logic [4:0] code;
  int nchk = 0, nerr = 0, nstb = 0, prev_stb = 0, prev_code = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swire_vcode_prog #(.MIN_LOW_TICKS(MINL), .MAX_LOW_TICKS(MAXL), .INIT_TICKS(INIT),
                     .STORE_TICKS(STORE), .OFF_TICKS(OFF)) i_swire_vcode_prog (
    .clk(clk), .rst_n(rst_n), .ctrl_line_i(ctrl),
    .rail_en_o(en), .vcode_o(code), .vcode_stb_o(stb));

  always @(posedge clk) if (stb) nstb++;

  function automatic int exp_code(input int edges);
    return (edges > 31) ? 31 : edges;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    ctrl = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int lo, input int hi);
    hold(1'b0, lo);
    hold(1'b1, hi);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enable", int'(en), 0);
    chk("R1 code", int'(code), 5);
    chk("R1 strobe", nstb, 0);

    hold(1'b1, 5);
    chk("R2 enable", int'(en), 1);
    chk("R2 code", int'(code), 5);
    chk("R2 strobes", nstb, 1);

    // pulses inside the init window
    pulse(6, 6);
    pulse(6, 6);
    hold(1'b1, 60);
    chk("R3 code", int'(code), 5);
    chk("R3 strobes", nstb, 1);

    // sweep of edge counts, each sequence restarts from zero
    prev_code = 5;
    for (int n = 1; n <= 33; n++) begin
      prev_stb = nstb;
      for (int k = 0; k < n; k++) pulse(6, 6);
      chk("R9 old code held", int'(code), prev_code);
      chk("R9 no early strobe", nstb, prev_stb);
      hold(1'b1, STORE + 10);
      chk((n > 31) ? "R7 saturated code" : "R4 code", int'(code), exp_code(n));
      chk("R6 one strobe", nstb, prev_stb + 1);
      prev_code = exp_code(n);
    end

    // width boundaries: 4,20 counted; 3,21,50 ignored
    prev_stb = nstb;
    pulse(MINL, 6);
    pulse(MINL - 1, 6);
    pulse(MAXL, 6);
    pulse(MAXL + 1, 6);
    pulse(OFF - 10, 6);
    chk("R5 enable kept", int'(en), 1);
    pulse(MINL, 6);
    pulse(MINL, 6);
    hold(1'b1, STORE + 10);
    chk("R5 code", int'(code), 4);
    chk("R5 strobes", nstb, prev_stb + 1);

    // store timing
    prev_stb = nstb;
    pulse(6, 6);
    pulse(6, 6);
    hold(1'b1, 14);
    chk("R6 no commit before store", nstb, prev_stb);
    chk("R6 code held", int'(code), 4);
    hold(1'b1, 20);
    chk("R6 commit", int'(code), 2);
    chk("R6 strobes", nstb, prev_stb + 1);

    // shutdown discards pending count
    pulse(6, 6);
    pulse(6, 6);
    pulse(6, 6);
    hold(1'b0, OFF + 5);
    chk("R8 disabled", int'(en), 0);
    chk("R8 code held", int'(code), 2);
    prev_stb = nstb;
    hold(1'b1, 5);
    chk("R8 re-enable", int'(en), 1);
    chk("R8 default code", int'(code), 5);
    hold(1'b1, INIT + STORE + 20);
    chk("R8 pending discarded", int'(code), 5);
    chk("R8 strobes", nstb, prev_stb + 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule